// File: doc/BRIEF.md
# Next-PC Sequencing Unit

This block holds the program counter of a processor that fetches fixed-length, 32-bit, word-aligned instructions. On every clock edge it loads the address of the next instruction. Four candidates are formed each cycle: the sequential address, a PC-relative conditional branch target, a region-local jump target and a register-indirect target. Decoded flow-control bits and an equality comparison of two register operands decide which candidate is loaded.

A decoder drives the flow-select bits and the immediate fields of the instruction at `pc_out`. The register file drives the two compare operands and the indirect target. The unit does not fetch, stall or take exceptions. Branches are word-relative: the 16-bit offset counts instructions and is measured from the incremented PC, never from the branch itself.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `pc_out` becomes 0x00000000 on that edge, whatever the other inputs are.
- R2: With `flow_sel` = 4'b0000, the next PC is PC + 4, wrapping modulo 2^32.
- R3: With only `flow_sel[0]` (branch-if-equal) set and `cmp_a` equal to `cmp_b`, the next PC is (PC + 4) + 4 × sign-extended `br_offset`. For example, an offset of 25 moves the PC 100 bytes past PC + 4.
- R4: With only `flow_sel[0]` set and the operands unequal, the next PC is PC + 4.
- R5: With only `flow_sel[1]` (branch-if-not-equal) set, the branch target of R3 is taken when the operands differ, and PC + 4 is loaded when they are equal. A taken one at 80012 with offset 2 gives 80024.
- R6: `br_offset` is two's complement. 0xFFFF steps back one word from PC + 4, 0x8000 steps back 32768 words and 0x7FFF steps forward 32767 words, all with 32-bit wrap.
- R7: With `flow_sel[2]` (jump) set and `flow_sel[3]` clear, the next PC keeps bits 31:28 of PC + 4 and puts `jmp_index` << 2 in bits 27:0.
- R8: With `flow_sel[3]` (register jump) set, the next PC is `jr_value` with bits 1:0 forced to zero.
- R9: When several select bits are set, the register jump wins over the jump, the jump wins over a taken branch, and a taken branch wins over the sequential address.
- R10: Bits 1:0 of `pc_out` are always 00 out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| flow_sel | input | 4 | Decoded flow control: bit0 branch-if-equal, bit1 branch-if-not-equal, bit2 jump, bit3 register jump |
| br_offset | input | 16 | Signed branch displacement in words |
| jmp_index | input | 26 | Word index for a region-local jump |
| cmp_a | input | 32 | First register operand of a branch compare |
| cmp_b | input | 32 | Second register operand of a branch compare |
| jr_value | input | 32 | Register-indirect jump target |
| pc_out | output | 32 | Current program counter |

## Verification
Each branch flavour is driven with equal and with unequal operands. This separates the eq/ne polarity and shows whether the comparison is used at all. Offsets of +25, -1, the most negative and the most positive value check the sign extension, the ×4 scaling and the PC + 4 base. A jump from 0xFFFFFFFC shows whether the region bits come from PC + 4 or from the PC itself. A misaligned register target checks the forced alignment. Stacked select bits check each level of the priority order, and a reset held while a register jump is requested shows that reset dominates.

// File: rtl/npc_pkg.sv
// Shared definitions for the next-PC sequencer.
// Assumes the flow-select bit positions below match the instruction decoder.
package npc_pkg;
    localparam int SEL_W   = 4;
    localparam int SEL_BEQ = 0;
    localparam int SEL_BNE = 1;
    localparam int SEL_JMP = 2;
    localparam int SEL_REG = 3;

    typedef enum logic [1:0] {
        SRC_SEQ = 2'd0,
        SRC_BR  = 2'd1,
        SRC_JMP = 2'd2,
        SRC_REG = 2'd3
    } next_src_e;
endpackage

// File: rtl/pc_target_calc.sv
// Forms the four candidate next addresses from the current PC.
// Assumes 4-byte instructions, so every displacement and index is scaled by 4
// and the jump region comes from the incremented PC.
module pc_target_calc #(
    parameter int AW = 32,
    parameter int OW = 16,
    parameter int JW = 26
) (
    input  logic [AW-1:0] pc,
    input  logic [OW-1:0] offset,
    input  logic [JW-1:0] index,
    input  logic [AW-1:0] reg_tgt_in,
    output logic [AW-1:0] seq_tgt,
    output logic [AW-1:0] br_tgt,
    output logic [AW-1:0] jmp_tgt,
    output logic [AW-1:0] reg_tgt
);
    localparam int RW = AW - JW - 2;
    localparam int XW = AW - OW - 2;
    localparam logic [AW-1:0] STEP = AW'(4);

    logic [AW-1:0] disp;

    // Sequential address and sign-extended, word-scaled branch displacement.
    always_comb begin
        seq_tgt = pc + STEP;
        disp    = {{XW{offset[OW-1]}}, offset, 2'b00};
        br_tgt  = seq_tgt + disp;
    end

    // Region-local jump and aligned register-indirect target.
    always_comb begin
        jmp_tgt = {seq_tgt[AW-1 -: RW], index, 2'b00};
        reg_tgt = {reg_tgt_in[AW-1:2], 2'b00};
    end
endmodule

// File: rtl/pc_branch_eval.sv
// Decides whether a conditional branch is taken.
// Assumes the eq and ne requests come straight from the decoder; either may be set.
module pc_branch_eval #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic          want_eq,
    input  logic          want_ne,
    output logic          taken
);
    logic same;

    // Equality compare and polarity select.
    always_comb begin
        same  = (op_a == op_b);
        taken = (want_eq && same) || (want_ne && !same);
    end
endmodule

// File: rtl/pc_source_pick.sv
// Priority encoder choosing the next-PC source.
// Order: register jump, jump, taken branch, sequential.
module pc_source_pick
    import npc_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic             br_taken,
    output next_src_e        src
);
    // Fixed-priority source choice.
    always_comb begin
        if (sel[SEL_REG])      src = SRC_REG;
        else if (sel[SEL_JMP]) src = SRC_JMP;
        else if (br_taken)     src = SRC_BR;
        else                   src = SRC_SEQ;
    end
endmodule

// File: rtl/pc_sequencer.sv
// Program-counter register with next-address selection.
// Assumes one instruction per cycle, with no stall, delay slot or exception.
// Reset is synchronous and active low and loads address zero.
module pc_sequencer
    import npc_pkg::*;
#(
    parameter int AW = 32,
    parameter int OW = 16,
    parameter int JW = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] flow_sel,
    input  logic [OW-1:0]    br_offset,
    input  logic [JW-1:0]    jmp_index,
    input  logic [AW-1:0]    cmp_a,
    input  logic [AW-1:0]    cmp_b,
    input  logic [AW-1:0]    jr_value,
    output logic [AW-1:0]    pc_out
);
    logic [AW-1:0] pc_q;
    logic [AW-1:0] pc_d;
    logic [AW-1:0] seq_tgt, br_tgt, jmp_tgt, reg_tgt;
    logic          br_taken;
    next_src_e     src;

    pc_target_calc #(.AW(AW), .OW(OW), .JW(JW)) u_calc (
        .pc        (pc_q),
        .offset    (br_offset),
        .index     (jmp_index),
        .reg_tgt_in(jr_value),
        .seq_tgt   (seq_tgt),
        .br_tgt    (br_tgt),
        .jmp_tgt   (jmp_tgt),
        .reg_tgt   (reg_tgt)
    );

    pc_branch_eval #(.DW(AW)) u_cmp (
        .op_a   (cmp_a),
        .op_b   (cmp_b),
        .want_eq(flow_sel[SEL_BEQ]),
        .want_ne(flow_sel[SEL_BNE]),
        .taken  (br_taken)
    );

    pc_source_pick u_pick (
        .sel     (flow_sel),
        .br_taken(br_taken),
        .src     (src)
    );

    // Next-address multiplexer.
    always_comb begin
        case (src)
            SRC_REG: pc_d = reg_tgt;
            SRC_JMP: pc_d = jmp_tgt;
            SRC_BR:  pc_d = br_tgt;
            default: pc_d = seq_tgt;
        endcase
    end

    // PC register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign pc_out = pc_q;
endmodule

// File: rtl/pc_sequencer_checker.sv
// Temporal checks for pc_sequencer, attached by bind.
// Assumes the default 32/16/26 field widths.
module pc_sequencer_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  flow_sel,
    input logic [15:0] br_offset,
    input logic [25:0] jmp_index,
    input logic [31:0] cmp_a,
    input logic [31:0] cmp_b,
    input logic [31:0] jr_value,
    input logic [31:0] pc_out
);
    logic        rst_seen_q;
    logic [31:0] m_seq, m_br, m_jmp;

    // Independent model of the candidate targets.
    always_comb begin
        m_seq = pc_out + 32'd4;
        m_br  = m_seq + (32'(signed'(br_offset)) <<< 2);
        m_jmp = {m_seq[31:28], jmp_index, 2'b00};
    end

    // Remembers that reset was sampled at the last edge.
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // Checks the PC after a reset edge.
    always @(negedge clk) begin
        if (rst_seen_q) begin
            assert_reset_zero_R1: assert (pc_out == 32'd0);
        end
    end

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flow_sel == 4'b0000 |=> pc_out == $past(m_seq));

    assert_beq_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_sel == 4'b0001 && cmp_a == cmp_b) |=> pc_out == $past(m_br));

    assert_beq_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_sel == 4'b0001 && cmp_a != cmp_b) |=> pc_out == $past(m_seq));

    assert_bne_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_sel == 4'b0010 && cmp_a != cmp_b) |=> pc_out == $past(m_br));

    assert_bne_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_sel == 4'b0010 && cmp_a == cmp_b) |=> pc_out == $past(m_seq));

    assert_jump_region_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_sel[3:2] == 2'b01) |=> pc_out == $past(m_jmp));

    assert_regjump_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flow_sel[3] |=> pc_out == {$past(jr_value[31:2]), 2'b00});

    assert_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pc_out[1:0] == 2'b00);
endmodule

bind pc_sequencer pc_sequencer_checker u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .flow_sel (flow_sel),
    .br_offset(br_offset),
    .jmp_index(jmp_index),
    .cmp_a    (cmp_a),
    .cmp_b    (cmp_b),
    .jr_value (jr_value),
    .pc_out   (pc_out)
);

// File: tb/pc_sequencer_bench.sv
// Vector-driven bench for pc_sequencer, followed by directed reset checks.
module pc_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  flow_sel;
    logic [15:0] br_offset;
    logic [25:0] jmp_index;
    logic [31:0] cmp_a, cmp_b, jr_value;
    logic [31:0] pc_out;
    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    pc_sequencer u_pc_sequencer (
        .clk(clk), .rst_n(rst_n), .flow_sel(flow_sel), .br_offset(br_offset),
        .jmp_index(jmp_index), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .jr_value(jr_value), .pc_out(pc_out)
    );

    typedef struct packed {
        logic [31:0] start;
        logic [3:0]  sel;
        logic [15:0] off;
        logic [25:0] idx;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] jrv;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{32'h0001388C, 4'b0010, 16'd2,    26'd0,        32'd1, 32'd2, 32'd0,         32'h00013898}, // R5 example 80012 -> 80024
        '{32'h00000100, 4'b0001, 16'd25,   26'd0,        32'd5, 32'd5, 32'd0,         32'h00000168}, // R3 25 words = 100 bytes
        '{32'h00000100, 4'b0001, 16'd25,   26'd0,        32'd5, 32'd6, 32'd0,         32'h00000104}, // R4
        '{32'h00000100, 4'b0010, 16'd25,   26'd0,        32'd7, 32'd7, 32'd0,         32'h00000104}, // R5 not taken
        '{32'h00000200, 4'b0001, 16'hFFFF, 26'd0,        32'd3, 32'd3, 32'd0,         32'h00000200}, // R6 minus one
        '{32'h00001000, 4'b0001, 16'h8000, 26'd0,        32'd3, 32'd3, 32'd0,         32'hFFFE1004}, // R6 most negative
        '{32'h00001000, 4'b0001, 16'h7FFF, 26'd0,        32'd3, 32'd3, 32'd0,         32'h00021000}, // R6 most positive
        '{32'hA0000010, 4'b0100, 16'd0,    26'h19,       32'd0, 32'd0, 32'd0,         32'hA0000064}, // R7
        '{32'hFFFFFFFC, 4'b0100, 16'd0,    26'h3FFFFFF,  32'd0, 32'd0, 32'd0,         32'h0FFFFFFC}, // R7 region from PC+4
        '{32'h00000010, 4'b1000, 16'd0,    26'd0,        32'd0, 32'd0, 32'h12345677,  32'h12345674}, // R8
        '{32'h00000010, 4'b1101, 16'd1,    26'h5,        32'd9, 32'd9, 32'h00000040,  32'h00000040}, // R9 reg jump first
        '{32'h00000010, 4'b0101, 16'd1,    26'h100,      32'd9, 32'd9, 32'd0,         32'h00000400}, // R9 jump over branch
        '{32'h00000010, 4'b0000, 16'd1,    26'h100,      32'd9, 32'd9, 32'h00000040,  32'h00000014}, // R2
        '{32'h7FFFFFFC, 4'b0000, 16'd0,    26'd0,        32'd0, 32'd0, 32'd0,         32'h80000000}  // R2 carry into top bit
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] s, input logic [15:0] o, input logic [25:0] i,
                         input logic [31:0] a, input logic [31:0] b, input logic [31:0] j);
        flow_sel = s; br_offset = o; jmp_index = i; cmp_a = a; cmp_b = b; jr_value = j;
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(4'b0000, '0, '0, '0, '0, '0);
        repeat (2) @(negedge clk);
        check("R1 reset value", pc_out, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 first step", pc_out, 32'd4);

        for (int k = 0; k < NV; k++) begin
            drive(4'b1000, '0, '0, '0, '0, VECS[k].start);
            @(negedge clk);
            drive(VECS[k].sel, VECS[k].off, VECS[k].idx, VECS[k].a, VECS[k].b, VECS[k].jrv);
            @(negedge clk);
            check($sformatf("vector %0d", k), pc_out, VECS[k].exp);
            check("R10 alignment", {30'd0, pc_out[1:0]}, 32'd0);
        end

        // R1: reset wins over a pending register jump.
        drive(4'b1000, '0, '0, '0, '0, 32'h55555554);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset over jump", pc_out, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 after reset", pc_out, 32'h55555554);
        drive(4'b0000, '0, '0, '0, '0, '0);
        @(negedge clk);
        check("R2 after jump", pc_out, 32'h55555558);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule